// File: doc/BRIEF.md
# Cascaded Match Result Bus Arbiter

Several match devices sit in a priority chain and share one result bus. Each device has a page number, a local match flag and a local active address. After a compare, only the highest-priority device that matched may put its page and active address on the bus. When no device anywhere in the chain matched, the device marked as last in the chain puts all ones on the bus instead. A "higher match present" signal passes from each device to the next lower-priority one. The chain is the only coordination between devices.

Each device takes an active-low cycle strobe and an active-low output enable. An operation is captured in the first clock where the strobe is low. The match flag and the active address take their new values in the first clock where the strobe is high again. The value and ownership of the result bus are recomputed only in clocks where the strobe is high, and are held while it is low. A direct read or write access also moves the active address, and the selected device then owns the bus. Real three-state pins are modelled as a value plus a drive-enable.

Top module: `match_chain_arbiter`

## Requirements
- R1: After a compare, with output enable low, only the device whose own match is set and whose chain input is low drives the bus. Every matched device with its chain input high stays off the bus.
- R2: While output enable (`oe_n`) is high, the device never asserts its drive-enable.
- R3: After a compare where no device matched, the device with `last_dev` high drives all ones. No other device drives.
- R4: When a device drives after a match or an access, the bus value is `{page_addr, active address}`, with the page in the upper bits.
- R5: The bus value is updated only in clocks where `strobe_n` is high. It holds its value through every clock where `strobe_n` is low.
- R6: The match flag updates only in the first strobe-high clock after a compare is captured. `chain_out` is high when `chain_in` is high or the local match flag is set.
- R7: A compare captured with `sel` low clears the local match flag, whatever `hit` is.
- R8: An access (`op` = 2) with `sel` high loads the active address from `acc_addr`, and that device drives the bus. Devices with `sel` low during an access release the bus.
- R9: After reset no device drives, and `chain_out` follows `chain_in`.
- R10: Operation codes are: `op` = 0 none, 1 compare, 2 access. Only the first non-zero `op` in a strobe-low period is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe_n | input | 1 | Active-low cycle strobe |
| oe_n | input | 1 | Active-low output enable |
| sel | input | 1 | Device selected for this operation |
| op | input | 2 | Operation code (0 none, 1 compare, 2 access) |
| hit | input | 1 | Local match result of the compare |
| hit_addr | input | ADDR_W | Local match address |
| acc_addr | input | ADDR_W | Address of a direct access |
| page_addr | input | PAGE_W | Page number of this device |
| last_dev | input | 1 | Device is last in the chain |
| chain_in | input | 1 | A higher-priority device has matched |
| chain_out | output | 1 | Higher match present, passed to the next device |
| bus_val | output | PAGE_W+ADDR_W | Result bus value |
| bus_en | output | 1 | Result bus drive-enable |

## Verification
The assertions assume that `chain_in` has settled before the strobe-high clock that recomputes ownership. This holds because upstream flags change only in that same strobe-high phase, and the stimulus always keeps the strobe high for two clocks. They also assume that `last_dev` and `page_addr` are static, and that `op` is non-zero only while the strobe is low. The bench ties the configuration inputs to constants per device and drives `op` back to zero before raising the strobe. It sweeps all sixteen hit patterns over a four-device chain.

// File: rtl/match_chain_arbiter.sv
module match_chain_arbiter #(
  parameter int PAGE_W = 2,
  parameter int ADDR_W = 4,
  localparam int BUS_W = PAGE_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_n,
  input  logic              oe_n,
  input  logic              sel,
  input  logic [1:0]        op,
  input  logic              hit,
  input  logic [ADDR_W-1:0] hit_addr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [PAGE_W-1:0] page_addr,
  input  logic              last_dev,
  input  logic              chain_in,
  output logic              chain_out,
  output logic [BUS_W-1:0]  bus_val,
  output logic              bus_en
);
  localparam logic [1:0] OP_NONE = 2'd0;
  localparam logic [1:0] OP_CMP  = 2'd1;
  localparam logic [1:0] OP_ACC  = 2'd2;

  typedef enum logic [1:0] {SRC_IDLE, SRC_CMP, SRC_ACC} src_t;

  logic [1:0]        pend_op;
  logic              pend_sel, pend_hit;
  logic [ADDR_W-1:0] pend_addr;
  logic              match_q;
  logic [ADDR_W-1:0] addr_q;
  src_t              src_q;
  logic [BUS_W-1:0]  bus_q;
  logic              own_q;

  logic win, miss, acc_own;
  assign win     = (src_q == SRC_CMP) && match_q && !chain_in;
  assign miss    = (src_q == SRC_CMP) && last_dev && !match_q && !chain_in;
  assign acc_own = (src_q == SRC_ACC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_op   <= OP_NONE;
      pend_sel  <= 1'b0;
      pend_hit  <= 1'b0;
      pend_addr <= '0;
      match_q   <= 1'b0;
      addr_q    <= '0;
      src_q     <= SRC_IDLE;
      bus_q     <= '0;
      own_q     <= 1'b0;
    end else if (!strobe_n) begin
      if (pend_op == OP_NONE && op != OP_NONE) begin
        pend_op   <= op;
        pend_sel  <= sel;
        pend_hit  <= hit;
        pend_addr <= (op == OP_CMP) ? hit_addr : acc_addr;
      end
    end else begin
      if (pend_op == OP_CMP) begin
        match_q <= pend_sel && pend_hit;
        src_q   <= SRC_CMP;
        if (pend_sel && pend_hit) addr_q <= pend_addr;
      end else if (pend_op == OP_ACC) begin
        src_q <= pend_sel ? SRC_ACC : SRC_IDLE;
        if (pend_sel) addr_q <= pend_addr;
      end
      pend_op <= OP_NONE;
      own_q   <= win || miss || acc_own;
      bus_q   <= miss ? {BUS_W{1'b1}} : {page_addr, addr_q};
    end
  end

  assign chain_out = chain_in || match_q;
  assign bus_val   = bus_q;
  assign bus_en    = !oe_n && own_q;
endmodule

module match_chain_arbiter_chk #(
  parameter int BUS_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             strobe_n,
  input logic             chain_in,
  input logic             last_dev,
  input logic             match_q,
  input logic [1:0]       src_q,
  input logic [BUS_W-1:0] bus_val,
  input logic             bus_en
);
  // R1
  lower_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_n && chain_in && src_q == 2'd1) |=> !bus_en);
  // R3
  miss_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_n && last_dev && src_q == 2'd1 && !match_q && !chain_in) |=> (bus_val == {BUS_W{1'b1}}));
  // R5
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_n |=> $stable(bus_val));
  // R6
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_n |=> $stable(match_q));
endmodule

bind match_chain_arbiter match_chain_arbiter_chk #(.BUS_W(BUS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .strobe_n(strobe_n), .chain_in(chain_in),
  .last_dev(last_dev), .match_q(match_q), .src_q(src_q),
  .bus_val(bus_val), .bus_en(bus_en)
);

// File: tb/match_chain_arbiter_tb.sv
module match_chain_arbiter_tb;
  localparam int N = 4;
  localparam int PW = 2;
  localparam int AW = 4;
  localparam int BW = PW + AW;

  logic clk = 0;
  always #5 clk = ~clk;

  logic rst_n, strobe_n, oe_n;
  logic [1:0] op;
  logic [N-1:0] sel, hit, chain_out;
  logic [N:0] chain;
  logic [AW-1:0] hit_addr [N];
  logic [AW-1:0] acc_addr [N];
  logic [BW-1:0] bus_val [N];
  logic [N-1:0] bus_en;

  int checks = 0, fails = 0;

  assign chain[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_dev
    assign chain[i+1] = chain_out[i];
    match_chain_arbiter #(.PAGE_W(PW), .ADDR_W(AW)) u_dut (
      .clk(clk), .rst_n(rst_n), .strobe_n(strobe_n), .oe_n(oe_n),
      .sel(sel[i]), .op(op), .hit(hit[i]), .hit_addr(hit_addr[i]),
      .acc_addr(acc_addr[i]), .page_addr(PW'(i)), .last_dev(i == N-1),
      .chain_in(chain[i]), .chain_out(chain_out[i]),
      .bus_val(bus_val[i]), .bus_en(bus_en[i]));
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int n_drv();
    int c = 0;
    for (int i = 0; i < N; i++) if (bus_en[i]) c++;
    return c;
  endfunction

  function automatic int drv_val();
    for (int i = 0; i < N; i++) if (bus_en[i]) return int'(bus_val[i]);
    return -1;
  endfunction

  function automatic int drv_idx();
    for (int i = 0; i < N; i++) if (bus_en[i]) return i;
    return -1;
  endfunction

  task automatic do_op(input logic [1:0] o);
    @(negedge clk); strobe_n = 0; op = o;
    @(negedge clk); strobe_n = 1; op = 0;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0; strobe_n = 1; oe_n = 0; op = 0; sel = '1; hit = '0;
    for (int i = 0; i < N; i++) begin hit_addr[i] = '0; acc_addr[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 reset state
    chk("R9 drivers", n_drv(), 0);
    chk("R9 chain", int'(chain_out), 0);

    // sweep all hit patterns: R1 R3 R4 R6 R2
    for (int p = 0; p < 16; p++) begin
      int k, ev;
      hit = 4'(p); sel = '1;
      for (int i = 0; i < N; i++) hit_addr[i] = AW'((p * 5 + i * 3) & 15);
      oe_n = 0;
      do_op(2'd1);
      k = -1;
      for (int i = N-1; i >= 0; i--) if (p[i]) k = i;
      ev = (k < 0) ? 63 : ((k << AW) | ((p * 5 + k * 3) & 15));
      chk(k < 0 ? "R3 drivers" : "R1 drivers", n_drv(), 1);
      chk(k < 0 ? "R3 owner" : "R1 owner", drv_idx(), (k < 0) ? N-1 : k);
      chk(k < 0 ? "R3 ones" : "R4 value", drv_val(), ev);
      chk("R6 chain", int'(chain_out[N-1]), (p != 0) ? 1 : 0);
      oe_n = 1;
      #1;
      chk("R2 released", n_drv(), 0);
      oe_n = 0;
    end

    // R5/R6: hold during strobe low (last pattern 15: device0 owns)
    hit = 4'b0000;
    @(negedge clk); strobe_n = 0; op = 2'd1;
    @(negedge clk); op = 0;
    @(negedge clk);
    chk("R5 held value", drv_val(), (0 << AW) | ((15 * 5) & 15));
    chk("R6 flag held", int'(chain_out[N-1]), 1);
    strobe_n = 1;
    @(negedge clk); @(negedge clk);
    chk("R3 ones after release", drv_val(), 63);

    // R10: only first op in a low period captured
    hit = 4'b0100; hit_addr[2] = 4'd7;
    @(negedge clk); strobe_n = 0; op = 2'd1;
    @(negedge clk); op = 2'd2; acc_addr[0] = 4'd9; sel = 4'b0001;
    @(negedge clk); strobe_n = 1; op = 0; sel = '1;
    @(negedge clk); @(negedge clk);
    chk("R10 first op", drv_val(), (2 << AW) | 7);

    // R7: deselected compare clears match
    hit = 4'b0101; hit_addr[0] = 4'd3; hit_addr[2] = 4'd7; sel = '1;
    do_op(2'd1);
    chk("R7 pre owner", drv_idx(), 0);
    sel = 4'b1110;
    do_op(2'd1);
    chk("R7 cleared", int'(chain_out[0]), 0);
    chk("R7 new owner", drv_idx(), 2);

    // R8: access
    sel = 4'b0010; acc_addr[1] = 4'd9;
    do_op(2'd2);
    chk("R8 drivers", n_drv(), 1);
    chk("R8 value", drv_val(), (1 << AW) | 9);
    sel = 4'b1000; acc_addr[3] = 4'd5;
    do_op(2'd2);
    chk("R8 moved", drv_val(), (3 << AW) | 5);
    chk("R8 single", n_drv(), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule